// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter with Ready/Valid Flow Control

This block is a finite impulse response filter for a scalar stream of signed samples. Its datapath is folded. It has a fixed number of coefficients set by a parameter. A small group of multiply-accumulate lanes shares the work, and each lane steps through its own slice of the taps, one tap per clock. As a result, every accepted sample occupies the datapath for a fixed number of cycles, called the fold factor. The filter output is produced at full precision. No rounding or saturation is applied.

Upstream logic offers samples with `in_valid` and watches `ready`. `ready` is high when the filter can take a sample on the coming clock edge. A producer that looks at `ready` one cycle late may leave `in_valid` high for one extra cycle. The filter keeps that one extra sample in a one-entry holding register and filters it immediately after the current sample. `ready` stays low until that work is nearly finished. The fold factor can be set directly as a cycle count, or it can be derived from a cap on the number of lanes. A synchronous reset empties the sample history, the lane accumulators, the holding register and the sequencing state.

Top module: `fir_serial_mac`

## Requirements
- R1: Each result equals the sum over k of c[k]*x[n-k] for k from 0 to NUM_TAPS-1, where x[n] is the newest processed sample and missing older samples count as zero. Samples and coefficients are signed two's complement. Coefficient k is held in `COEFS[k*COEF_W +: COEF_W]`. `out_data` is signed and DATA_W+COEF_W+ceil(log2(NUM_TAPS)) bits wide, with no rounding or saturation.
- R2: A sample is accepted on a rising edge where `in_valid` and `ready` are both high. If it is accepted in clock cycle t, `out_valid` is high for exactly one cycle, in cycle t+FOLD+1, and `out_data` carries that sample's result in the same cycle.
- R3: `ready` is low in the cycle after an acceptance. If nothing is held, `ready` returns high in the last processing cycle (t+FOLD). This lets a producer that always offers data get one sample accepted every FOLD cycles.
- R4: In cycle mode (SIZE_BY_MACS=0), FOLD = min(CYCLES, NUM_TAPS), so CYCLES at or above NUM_TAPS gives a single lane. In lane mode, FOLD = ceil(NUM_TAPS/MAC_LIMIT). The number of lanes is ceil(NUM_TAPS/FOLD), and any tap slots beyond NUM_TAPS have zero coefficients.
- R5: A sample offered with `in_valid` high in the cycle right after an acceptance, while `ready` is low, is stored rather than lost. It is processed as the next sample, and its result appears FOLD cycles after the previous result. `ready` stays low until the last processing cycle of that stored sample.
- R6: A sample offered while `ready` is low, in any cycle other than the one right after an acceptance, is ignored. It produces no output and does not enter the history.
- R7: The synchronous reset `rst` clears the history, the accumulators, any held sample and the output valid. In the first cycle after reset, `ready` is 1 and `out_valid` is 0, and later results are computed as if all earlier samples were zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_data | input | DATA_W | Signed input sample |
| ready | output | 1 | A sample can be taken on the next edge |
| out_valid | output | 1 | One-cycle strobe marking a finished result |
| out_data | output | DATA_W+COEF_W+ceil(log2(NUM_TAPS)) | Signed full-precision filter result |

## Verification
The hardest condition to reach is the late sample. `in_valid` must be high in exactly the one cycle after an acceptance, and the bench must then confirm that the held sample's result arrives one full fold later and that `ready` stays low across both sample periods. The hardest variant is a reset that arrives while a sample is held. The bench drives these patterns deliberately, both back-to-back and interleaved with randomly chosen handshake modes. Those modes include offers made in a cycle that must be ignored. Every result is checked for both its value and the exact cycle it appears, against a convolution model kept in the bench.

// File: rtl/fir_serial_pkg.sv
package fir_serial_pkg;

    function automatic int ceil_div(input int num, input int den);
        int d;
        d = (den < 1) ? 1 : den;
        return (num + d - 1) / d;
    endfunction

    // Fold factor: cycles each sample occupies the lanes
    function automatic int pick_fold(input int taps, input int cycles,
                                     input int by_macs, input int mac_limit);
        if (by_macs != 0) begin
            return ceil_div(taps, mac_limit);
        end
        if (cycles < 1) begin
            return 1;
        end
        return (cycles >= taps) ? taps : cycles;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fir_serial_ctrl.sv
module fir_serial_ctrl #(
    parameter int DATA_W = 8,
    parameter int FOLD   = 3,
    parameter int PH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              ready,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic [PH_W-1:0]   phase,
    output logic              first,
    output logic              last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FOLD - 1);

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   phase;
        logic              ready;
        logic              late_ok;
        logic              held;
        logic [DATA_W-1:0] held_data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic accept, capture, release_held;

    always_comb begin
        st_d         = st_q;
        accept       = in_valid && st_q.ready;
        capture      = in_valid && !st_q.ready && st_q.late_ok && !st_q.held;
        last         = st_q.busy && (st_q.phase == LAST_PH);
        first        = st_q.busy && (st_q.phase == '0);
        release_held = last && st_q.held;
        load         = accept || release_held;
        load_data    = release_held ? st_q.held_data : in_data;

        st_d.late_ok = accept;
        if (capture) begin
            st_d.held      = 1'b1;
            st_d.held_data = in_data;
        end else if (release_held) begin
            st_d.held = 1'b0;
        end

        if (load) begin
            st_d.busy  = 1'b1;
            st_d.phase = '0;
        end else if (last) begin
            st_d.busy  = 1'b0;
            st_d.phase = '0;
        end else if (st_q.busy) begin
            st_d.phase = st_q.phase + 1'b1;
        end

        st_d.ready = !st_d.held && (!st_d.busy || (st_d.phase == LAST_PH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
    assign busy  = st_q.busy;
    assign phase = st_q.phase;

    // A held sample must keep the input closed
    assert_held_blocks_ready_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.held |-> !st_q.ready);

    // Final processing cycle with nothing held opens the input
    assert_ready_in_last_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.phase == LAST_PH && !st_q.held) |-> st_q.ready);

    generate
        if (FOLD > 1) begin : g_multi
            assert_drop_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && ready) |=> !ready);
        end
    endgenerate
endmodule

// File: rtl/fir_mac_lane.sv
module fir_mac_lane #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int FOLD   = 3,
    parameter int PH_W   = 2,
    parameter int ACC_W  = 19,
    parameter logic [FOLD*COEF_W-1:0] BANK = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   busy,
    input  logic                   first,
    input  logic [PH_W-1:0]        phase,
    input  logic [FOLD*DATA_W-1:0] samples,
    output logic [ACC_W-1:0]       sum_now
);
    localparam int PROD_W = DATA_W + COEF_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic signed [DATA_W-1:0] smp;
    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  base;
    logic signed [ACC_W-1:0]  total;

    always_comb begin
        smp  = '0;
        coef = '0;
        for (int p = 0; p < FOLD; p++) begin
            if (int'(phase) == p) begin
                smp  = samples[p*DATA_W +: DATA_W];
                coef = BANK[p*COEF_W +: COEF_W];
            end
        end
        prod  = smp * coef;
        base  = first ? '0 : st_q.acc;
        total = base + ACC_W'(prod);
        st_d  = st_q;
        if (busy) begin
            st_d.acc = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_now = total;
endmodule

// File: rtl/fir_partial_sum.sv
module fir_partial_sum #(
    parameter int LANES = 3,
    parameter int ACC_W = 19
) (
    input  logic [LANES*ACC_W-1:0] parts,
    output logic [ACC_W-1:0]       total
);
    always_comb begin
        total = '0;
        for (int m = 0; m < LANES; m++) begin
            total = total + parts[m*ACC_W +: ACC_W];
        end
    end
endmodule

// File: rtl/fir_serial_mac.sv
module fir_serial_mac
    import fir_serial_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int COEF_W       = 8,
    parameter int NUM_TAPS     = 7,
    parameter int CYCLES       = 3,
    parameter int SIZE_BY_MACS = 0,
    parameter int MAC_LIMIT    = 1,
    parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
        {8'hFE, 8'h01, 8'h80, 8'h7F, 8'h11, 8'hFB, 8'h03}
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             in_valid,
    input  logic [DATA_W-1:0]                                in_data,
    output logic                                             ready,
    output logic                                             out_valid,
    output logic [DATA_W+COEF_W+$clog2(NUM_TAPS)-1:0]        out_data
);
    localparam int FOLD  = pick_fold(NUM_TAPS, CYCLES, SIZE_BY_MACS, MAC_LIMIT);
    localparam int LANES = ceil_div(NUM_TAPS, FOLD);
    localparam int SLOTS = LANES * FOLD;
    localparam int PH_W  = idx_width(FOLD);
    localparam int ACC_W = DATA_W + COEF_W + $clog2(NUM_TAPS);
    localparam logic [SLOTS*COEF_W-1:0] COEF_PAD = (SLOTS*COEF_W)'(COEFS);

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] line;
        logic                         out_valid;
        logic [ACC_W-1:0]             out_data;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              load, busy, first, last;
    logic [DATA_W-1:0] load_data;
    logic [PH_W-1:0]   phase;
    logic [LANES*ACC_W-1:0] parts;
    logic [ACC_W-1:0]  total;

    fir_serial_ctrl #(
        .DATA_W(DATA_W), .FOLD(FOLD), .PH_W(PH_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .ready(ready), .load(load), .load_data(load_data), .busy(busy),
        .phase(phase), .first(first), .last(last)
    );

    generate
        for (genvar m = 0; m < LANES; m++) begin : g_lane
            logic [FOLD*DATA_W-1:0] bank_samples;
            assign bank_samples = st_q.line[m*FOLD +: FOLD];
            fir_mac_lane #(
                .DATA_W(DATA_W), .COEF_W(COEF_W), .FOLD(FOLD), .PH_W(PH_W),
                .ACC_W(ACC_W), .BANK(COEF_PAD[m*FOLD*COEF_W +: FOLD*COEF_W])
            ) u_lane (
                .clk(clk), .rst(rst), .busy(busy), .first(first), .phase(phase),
                .samples(bank_samples), .sum_now(parts[m*ACC_W +: ACC_W])
            );
        end
    endgenerate

    fir_partial_sum #(.LANES(LANES), .ACC_W(ACC_W)) u_sum (
        .parts(parts), .total(total)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            for (int i = SLOTS - 1; i > 0; i--) begin
                st_d.line[i] = st_q.line[i-1];
            end
            st_d.line[0] = load_data;
        end
        st_d.out_valid = busy && last;
        if (busy && last) begin
            st_d.out_data = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    generate
        if (FOLD > 1) begin : g_pulse
            assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
                out_valid |=> !out_valid);
        end
    endgenerate
endmodule

// File: tb/sim_fir_serial_mac.sv
`timescale 1ns/1ps
module sim_fir_serial_mac;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int TAPS  = 7;
    localparam int FOLD  = 3;   // min(CYCLES=3, TAPS=7)
    localparam int AW    = DW + CW + 3;
    localparam logic [TAPS*CW-1:0] CV =
        {8'hFE, 8'h01, 8'h80, 8'h7F, 8'h11, 8'hFB, 8'h03};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic ready, out_valid;
    logic signed [AW-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    int hist_q[$];
    int exp_val[$];
    int exp_due[$];
    string exp_tag[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fir_serial_mac #(.DATA_W(DW), .COEF_W(CW), .NUM_TAPS(TAPS), .CYCLES(3),
                     .SIZE_BY_MACS(0), .MAC_LIMIT(1), .COEFS(CV)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .ready(ready), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int coef_at(input int k);
        logic signed [CW-1:0] c;
        c = CV[k*CW +: CW];
        return int'(c);
    endfunction

    function automatic int model_push(input int x);
        int s;
        hist_q.push_front(x);
        if (hist_q.size() > TAPS) void'(hist_q.pop_back());
        s = 0;
        for (int k = 0; k < hist_q.size(); k++) s += coef_at(k) * hist_q[k];
        return s;
    endfunction

    task automatic check(input bit ok, input string msg, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    // mode 0: offer once; 1: late sample next cycle; 2: ignored offer two cycles later
    task automatic offer(input int x, input int mode, input int extra);
        int t;
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        t = cyc;
        exp_val.push_back(model_push(x));
        exp_due.push_back(t + FOLD + 1);
        exp_tag.push_back("R1/R2");
        @(negedge clk);
        if (mode == 1) begin
            in_data = DW'(extra);
            exp_val.push_back(model_push(extra));
            exp_due.push_back(t + 2*FOLD + 1);
            exp_tag.push_back("R5");
            @(negedge clk);
            in_valid = 1'b0;
        end else if (mode == 2) begin
            in_valid = 1'b0;
            @(negedge clk);
            in_valid = 1'b1;  // R6: must be ignored
            in_data  = DW'(extra);
            @(negedge clk);
            in_valid = 1'b0;
        end else begin
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        hist_q.delete();
        exp_val.delete();
        exp_due.delete();
        exp_tag.delete();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b1, "R7 ready after reset", int'(ready), 1);
        check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                checks++;
                if (exp_val.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected output actual=%0d expected=none", int'(out_data));
                end else begin
                    int v, d;
                    string tg;
                    v = exp_val.pop_front();
                    d = exp_due.pop_front();
                    tg = exp_tag.pop_front();
                    if (int'(out_data) != v || d != cyc) begin
                        fails++;
                        $display("FAIL %s value actual=%0d expected=%0d cycle actual=%0d expected=%0d",
                                 tg, int'(out_data), v, cyc, d);
                    end
                end
            end else if (exp_due.size() > 0 && exp_due[0] <= cyc) begin
                checks++;
                fails++;
                $display("FAIL %s missing output actual=none expected=%0d at cycle %0d",
                         exp_tag[0], exp_val[0], exp_due[0]);
                void'(exp_val.pop_front());
                void'(exp_due.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b1, "R7 ready at start", int'(ready), 1);
        check(out_valid == 1'b0, "R7 out_valid at start", int'(out_valid), 0);

        // R1: impulse exposes coefficient order
        offer(1, 0, 0);
        for (int i = 0; i < TAPS; i++) offer(0, 0, 0);

        // R3/R4: ready profile around one acceptance
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; in_data = DW'(5);
        exp_val.push_back(model_push(5));
        exp_due.push_back(cyc + FOLD + 1);
        exp_tag.push_back("R3");
        @(negedge clk);
        in_valid = 1'b0;
        check(ready == 1'b0, "R3 ready low after accept", int'(ready), 0);
        @(negedge clk);
        check(ready == 1'b0, "R3/R4 ready low mid-sample", int'(ready), 0);
        @(negedge clk);
        check(ready == 1'b1, "R3/R4 ready high in last fold cycle", int'(ready), 1);

        // R1 extremes at maximum rate
        for (int i = 0; i < 8; i++) offer(127, 0, 0);
        for (int i = 0; i < 8; i++) offer(-128, 0, 0);

        // R5: late samples, back to back
        offer(-128, 1, 127);
        offer(100, 1, -77);
        // R5: check ready held low through the stored sample
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; in_data = DW'(9);
        exp_val.push_back(model_push(9));
        exp_due.push_back(cyc + FOLD + 1);
        exp_tag.push_back("R5");
        begin
            int t0;
            t0 = cyc;
            @(negedge clk);
            in_data = DW'(-3);
            exp_val.push_back(model_push(-3));
            exp_due.push_back(t0 + 2*FOLD + 1);
            exp_tag.push_back("R5");
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check(ready == 1'b0, "R5 ready low while stored sample waits", int'(ready), 0);
        end

        // R6: ignored offers
        offer(33, 2, 111);
        offer(-50, 2, -99);

        // R7: reset while a stored sample is pending
        offer(64, 1, 64);
        do_reset();
        offer(7, 0, 0);
        offer(-2, 0, 0);

        // Random mix
        for (int i = 0; i < 90; i++) begin
            int mode, x, y;
            mode = int'($urandom % 4);
            x = int'($urandom % 256) - 128;
            y = int'($urandom % 256) - 128;
            offer(x, (mode == 3) ? 0 : mode, y);
            if ($urandom % 5 == 0) repeat (int'($urandom % 6)) @(negedge clk);
        end

        while (exp_val.size() > 0) @(negedge clk);
        repeat (12) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule